// File: doc/BRIEF.md
# MDIO Management Controller

This block lets software reach the management registers of an external Ethernet PHY over the two-wire clause-22 serial management bus. Software sees two registers on a simple write/read port. The command register holds the target PHY address, the target register number and two request bits. The staging register holds the 16-bit value for a write. Setting a request bit starts a frame. That bit then reads back as 1 until the frame has finished, and software polls it to learn that the transaction is complete.

A read places the 16 bits returned by the PHY in the low half of the command register. If no PHY answers, the pulled-up data line gives all ones. The management clock comes from the system clock through a divider. The divider ratio is derived from the system clock frequency and a ceiling on the management clock rate. Outgoing bits change when the management clock falls, and incoming bits are captured when it rises. The data pin is split into an output, an output enable and an input, so that a pad cell outside the block can form the bidirectional pin.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset the command register reads 0, `mdc` is low and `mdioOe` is low.
- R2: Address 0 is the command register, laid out as: [15:0] read result, [20:16] PHY address, [25:21] register number, bit 26 read request, bit 27 write request, [31:28] zero. Address 1 is the write staging register, which holds bits [15:0] and reads with bits [31:16] zero. The staging register accepts writes at any time. A transaction uses the value the staging register holds when the transaction starts.
- R3: While a transaction runs, each high phase and each low phase of `mdc` lasts HALF system clocks, where HALF = ceil(CLK_HZ / (2*MDC_MAX_HZ)). When idle, `mdc` stays low.
- R4: Every frame is 64 `mdc` periods long. It sends 32 ones, then the start bits 0 and 1, then the opcode (1,0 for a read; 0,1 for a write), then the PHY address MSB first, then the register number MSB first.
- R5: A write frame drives all 64 bits. The turnaround bits are 1 then 0, followed by the staged data MSB first.
- R6: A read frame drives the line for bits 0 to 45 only. It releases the line for the two turnaround bits and the 16 data bits. The 16 values sampled at the `mdc` rising edges of bits 48 to 63 land MSB first in command bits [15:0] when the frame ends.
- R7: `mdioOut` and `mdioOe` change only at the edge where `mdc` falls, or at the start of a frame while `mdc` is low. They never change during an `mdc` high phase.
- R8: The request bit that started a frame reads 1 for exactly 128*HALF system clocks and then clears itself. No new frame can start while it is set.
- R9: A command-register write that arrives while a frame is in progress is ignored entirely: the fields and the request bits stay unchanged.
- R10: If both request bits are written as 1, the block performs a read. A command write with neither request bit updates the PHY address and register fields without starting a frame.
- R11: A read from a PHY that does not drive the line (input held high) returns 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address (0 command, 1 staging) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Management data output value |
| mdioOe | output | 1 | Management data output enable |
| mdioIn | input | 1 | Management data input from the pad |

## Verification
The assertions assume that `mdioIn` changes only while `mdc` is low, and that software writes the command register only at address 0 while it polls. The bench meets both conditions. Its PHY model updates `mdioIn` only at the falling edges of `mdc`, and it holds `regAddr` at 0 for the whole time it polls a transaction. Random transactions use random addresses, data and opcodes. Directed cases inject a conflicting command in the middle of a frame, set both request bits, write a command with no request bit, and read from an absent PHY.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_BIT     = 46;
  localparam int DATA_BIT   = 48;
  localparam int PHY_LSB    = 16;
  localparam int REG_LSB    = 21;
  localparam int RD_BIT     = 26;
  localparam int WR_BIT     = 27;
  localparam int CMD_ADDR   = 0;
  localparam int DATA_ADDR  = 1;

  typedef struct packed {
    logic load;      // start a frame this cycle
    logic loadRead;  // the frame being started is a read
    logic shift;     // advance the outgoing bit
    logic sample;    // capture an incoming data bit
    logic done;      // frame ends this cycle
    logic driveEn;   // controller owns the data line
  } mdioStrobes_t;
endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic mdc,
  output logic riseTick,
  output logic fallTick
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic wrap;

  assign wrap     = run && (cnt == LAST);
  assign riseTick = wrap && !mdc;
  assign fallTick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_mgmt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdWrite,
  input  logic         rdReq,
  input  logic         wrReq,
  input  logic         riseTick,
  input  logic         fallTick,
  output logic         busy,
  output mdioStrobes_t strobes
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] TA_IDX    = CNT_W'(TA_BIT);
  localparam logic [CNT_W-1:0] DATA_IDX  = CNT_W'(DATA_BIT);

  logic [CNT_W-1:0] bitCnt;
  logic isRead;
  logic start;
  logic lastBit;

  assign start   = cmdWrite && !busy && (rdReq || wrReq);
  assign lastBit = (bitCnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      isRead <= 1'b0;
      bitCnt <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      isRead <= rdReq;
      bitCnt <= '0;
    end else if (busy && fallTick) begin
      if (lastBit) busy <= 1'b0;
      else         bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.load     = start;
    strobes.loadRead = rdReq;
    strobes.shift    = busy && fallTick && !lastBit;
    strobes.sample   = busy && riseTick && isRead && (bitCnt >= DATA_IDX);
    strobes.done     = busy && fallTick && lastBit;
    strobes.driveEn  = busy && (!isRead || (bitCnt < TA_IDX));
  end

  // R8: a frame only ends at a falling management clock tick
  p_end_on_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(fallTick));
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic              cmdWrite,
  input  logic              busy,
  input  mdioStrobes_t      strobes,
  input  logic              mdioIn,
  output logic [31:0]       regRdData,
  output logic              mdioOut,
  output logic              mdioOe
);
  logic [4:0]  phyAd;
  logic [4:0]  regAd;
  logic [15:0] rdData;
  logic [15:0] wrData;
  logic        reqRd;
  logic        reqWr;
  logic [FRAME_BITS-1:0] txShift;
  logic [15:0] rxShift;
  logic [FRAME_BITS-1:0] frameImage;
  logic [4:0]  newPhy;
  logic [4:0]  newReg;

  assign newPhy = regWrData[PHY_LSB +: 5];
  assign newReg = regWrData[REG_LSB +: 5];

  always_comb begin
    frameImage = {32'hFFFF_FFFF, 2'b01,
                  strobes.loadRead ? 2'b10 : 2'b01,
                  newPhy, newReg,
                  strobes.loadRead ? 2'b11 : 2'b10,
                  strobes.loadRead ? 16'hFFFF : wrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyAd   <= '0;
      regAd   <= '0;
      rdData  <= '0;
      wrData  <= '0;
      reqRd   <= 1'b0;
      reqWr   <= 1'b0;
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (regWrEn && (regAddr == ADDR_W'(DATA_ADDR)))
        wrData <= regWrData[15:0];
      if (cmdWrite && !busy) begin
        phyAd <= newPhy;
        regAd <= newReg;
      end
      if (strobes.load) begin
        reqRd   <= strobes.loadRead;
        reqWr   <= !strobes.loadRead;
        txShift <= frameImage;
      end else if (strobes.shift) begin
        txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
      end
      if (strobes.sample)
        rxShift <= {rxShift[14:0], mdioIn};
      if (strobes.done) begin
        reqRd <= 1'b0;
        reqWr <= 1'b0;
        if (reqRd) rdData <= rxShift;
      end
    end
  end

  assign mdioOut = txShift[FRAME_BITS-1];
  assign mdioOe  = strobes.driveEn;

  always_comb begin
    if (regAddr == ADDR_W'(CMD_ADDR))
      regRdData = {4'b0, reqWr, reqRd, regAd, phyAd, rdData};
    else if (regAddr == ADDR_W'(DATA_ADDR))
      regRdData = {16'b0, wrData};
    else
      regRdData = '0;
  end

  // R8: a request bit is visible exactly while the engine is busy
  p_req_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqRd || reqWr) == busy);
  // R10: never both requests pending
  p_one_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqRd, reqWr}));
  // R9: command writes during a frame leave the fields alone
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWrite) |=> ($stable(phyAd) && $stable(regAd) && $stable(reqRd)));
  // R6: read result only moves at the end of a frame
  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.done |=> $stable(rdData));
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_mgmt_pkg::*;
#(
  parameter int CLK_HZ     = 10_000_000,
  parameter int MDC_MAX_HZ = 2_500_000,
  parameter int ADDR_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  localparam int HALF_CYC = (CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);

  mdioStrobes_t strobes;
  logic busy;
  logic riseTick;
  logic fallTick;
  logic cmdWrite;

  assign cmdWrite = regWrEn && (regAddr == ADDR_W'(CMD_ADDR));

  mdio_mdc_div #(.HALF_CYC(HALF_CYC)) u_div (
    .clk(clk), .rstN(rstN), .run(busy),
    .mdc(mdc), .riseTick(riseTick), .fallTick(fallTick)
  );

  mdio_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite),
    .rdReq(regWrData[RD_BIT]), .wrReq(regWrData[WR_BIT]),
    .riseTick(riseTick), .fallTick(fallTick),
    .busy(busy), .strobes(strobes)
  );

  mdio_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .cmdWrite(cmdWrite), .busy(busy),
    .strobes(strobes), .mdioIn(mdioIn), .regRdData(regRdData),
    .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  // R3: management clock parked low when idle
  p_idle_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);
  // R7: outputs hold through every high phase
  p_drive_on_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> ($stable(mdioOut) && $stable(mdioOe)));
endmodule

// File: tb/mdio_mgmt_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_tb;
  localparam int CLK_PERIOD = 100;
  localparam int CLK_HZ     = 10_000_000;
  localparam int MDC_MAX_HZ = 2_500_000;
  localparam int HALF_EXP   = (CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic mdc, mdioOut, mdioOe;
  logic mdioIn = 1'b1;

  always #(CLK_PERIOD / 2) clk = !clk;

  mdio_mgmt #(.CLK_HZ(CLK_HZ), .MDC_MAX_HZ(MDC_MAX_HZ), .ADDR_W(2)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // PHY model and line monitor
  logic frameBits [64];
  logic oeBits [64];
  int riseCnt = 0;
  int lowLen = 0;
  int highLen = 0;
  int widthErr = 0;
  int driveErr = 0;
  logic prevMdc = 1'b0;
  logic prevOut = 1'b0;
  logic prevOe = 1'b0;
  logic phyPresent = 1'b1;
  logic [15:0] phyValue = '0;

  always @(negedge clk) begin
    if (mdc && !prevMdc) begin
      if (lowLen != HALF_EXP) widthErr++;
      lowLen = 0;
      if (riseCnt < 64) begin
        frameBits[riseCnt] = mdioOut;
        oeBits[riseCnt] = mdioOe;
      end
      riseCnt++;
    end
    if (!mdc && prevMdc) begin
      if (highLen != HALF_EXP) widthErr++;
      highLen = 0;
      if (riseCnt >= 48 && riseCnt <= 63 && phyPresent)
        mdioIn = phyValue[63 - riseCnt];
      else if (riseCnt == 47 && phyPresent)
        mdioIn = 1'b0;
      else
        mdioIn = 1'b1;
    end
    if (mdc && prevMdc && (mdioOut != prevOut || mdioOe != prevOe)) driveErr++;
    if (mdc) highLen++;
    else if (regAddr == 2'd0 && (regRdData[26] || regRdData[27])) lowLen++;
    prevMdc = mdc;
    prevOut = mdioOut;
    prevOe = mdioOe;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 2'd0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
    regAddr = 2'd0;
  endtask

  function automatic logic [63:0] expFrame(input bit rd, input logic [4:0] p,
                                           input logic [4:0] r, input logic [15:0] w);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, p, r,
            rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : w};
  endfunction

  function automatic logic [31:0] cmdWord(input bit rdb, input bit wrb,
                                          input logic [4:0] p, input logic [4:0] r);
    return {4'b0, wrb, rdb, r, p, 16'h0};
  endfunction

  // mode: 0 read, 1 write, 2 both bits (expect read), with optional intrusion
  task automatic runTxn(input int mode, input logic [4:0] p, input logic [4:0] r,
                        input logic [15:0] w, input bit intrude);
    bit rd;
    int cyc;
    logic [63:0] ef;
    logic [31:0] rb;
    logic [15:0] expData;
    rd = (mode != 1);
    riseCnt = 0; widthErr = 0; driveErr = 0; lowLen = 0; highLen = 0;
    for (int i = 0; i < 64; i++) begin frameBits[i] = 1'bx; oeBits[i] = 1'bx; end
    regWrite(2'd1, {16'h0, w});
    regWrite(2'd0, cmdWord(mode != 1, mode != 0, p, r));
    cyc = 0;
    while ((regRdData[26] || regRdData[27]) && cyc < 5000) begin
      if (intrude && cyc == 10) begin
        regAddr = 2'd0; regWrEn = 1'b1;
        regWrData = cmdWord(1'b0, 1'b1, ~p, ~r);
      end else begin
        regWrEn = 1'b0;
      end
      cyc++;
      @(negedge clk);
    end
    regWrEn = 1'b0;
    check(cyc == 128 * HALF_EXP, "R8", "busy cycles", cyc, 128 * HALF_EXP);
    check(riseCnt == 64, "R4", "mdc periods", riseCnt, 64);
    check(widthErr == 0, "R3", "mdc phase widths wrong", widthErr, 0);
    check(driveErr == 0, "R7", "output moved in high phase", driveErr, 0);
    ef = expFrame(rd, p, r, w);
    begin
      logic [45:0] gotHead;
      logic [45:0] oeHead;
      for (int i = 0; i < 46; i++) begin
        gotHead[45 - i] = frameBits[i];
        oeHead[45 - i] = oeBits[i];
      end
      check(gotHead === ef[63:18], "R4", "frame head", gotHead, ef[63:18]);
      check(oeHead === {46{1'b1}}, "R4", "head drive", oeHead, {46{1'b1}});
    end
    begin
      logic [17:0] gotTail;
      logic [17:0] oeTail;
      for (int i = 46; i < 64; i++) begin
        gotTail[63 - i] = frameBits[i];
        oeTail[63 - i] = oeBits[i];
      end
      if (rd)
        check(oeTail === 18'h0, "R6", "tail released", oeTail, 0);
      else begin
        check(oeTail === 18'h3FFFF, "R5", "tail driven", oeTail, 18'h3FFFF);
        check(gotTail === ef[17:0], "R5", "ta+data", gotTail, ef[17:0]);
      end
    end
    regRead(2'd0, rb);
    check(rb[20:16] == p && rb[25:21] == r && rb[27:26] == 2'b00, "R2",
          "fields after frame", rb[31:16], {4'b0, 2'b00, r, p});
    if (intrude)
      check(rb[20:16] == p, "R9", "intruding command ignored", rb[20:16], p);
    if (rd) begin
      expData = phyPresent ? phyValue : 16'hFFFF;
      check(rb[15:0] == expData, phyPresent ? "R6" : "R11", "read data", rb[15:0], expData);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] rb;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(regRdData == 32'h0, "R1", "cmd after reset", regRdData, 0);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R1", "pins after reset", {mdc, mdioOe}, 0);

    // R2 staging register readback
    regWrite(2'd1, 32'hFFFF_A5C3);
    regRead(2'd1, rb);
    check(rb == 32'h0000_A5C3, "R2", "staging readback", rb, 32'h0000_A5C3);

    // R10 command without request bits: fields only, no frame
    regWrite(2'd0, cmdWord(1'b0, 1'b0, 5'd7, 5'd3));
    repeat (20) begin
      @(negedge clk);
      if (mdc) break;
    end
    check(mdc == 1'b0, "R10", "no frame without request", mdc, 0);
    regRead(2'd0, rb);
    check(rb == cmdWord(1'b0, 1'b0, 5'd7, 5'd3), "R10", "fields only", rb,
          cmdWord(1'b0, 1'b0, 5'd7, 5'd3));

    // directed write and read
    phyPresent = 1'b1; phyValue = 16'h8001;
    runTxn(1, 5'h1F, 5'h00, 16'hDEAD, 1'b0);
    runTxn(0, 5'h01, 5'h1F, 16'h0000, 1'b0);
    // R10 both request bits -> read
    phyValue = 16'h3C5A;
    runTxn(2, 5'h0A, 5'h15, 16'h1234, 1'b0);
    // R9 intruding command while busy
    phyValue = 16'h7E81;
    runTxn(0, 5'h05, 5'h0C, 16'h0000, 1'b1);
    runTxn(1, 5'h12, 5'h09, 16'hBEEF, 1'b1);
    // R11 absent PHY
    phyPresent = 1'b0;
    runTxn(0, 5'h1E, 5'h02, 16'h0000, 1'b0);
    phyPresent = 1'b1;

    // random mix
    for (int n = 0; n < 12; n++) begin
      phyValue = 16'($urandom);
      runTxn(int'($urandom % 3), 5'($urandom), 5'($urandom), 16'($urandom), 1'b0);
    end

    finishRun();
  end
endmodule